// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line. A word arrives with a one-cycle load strobe and waits in a one-entry holding register. When the shifter is free, the word moves in and is sent as follows: a low start bit, then 5 to 8 data bits least significant first, then an optional parity bit, then a stop period at the high level. The line rests high between frames.

Bit timing comes from an external tick at 16 times the bit rate, so every bit spans 16 ticks. The frame format is set by inputs that are sampled when a word moves into the shifter: word length, stop length, parity on or off, parity sense and fixed-level parity. A break input holds the line low for as long as it is set. Two status outputs report an empty holding register and a fully idle transmitter.

Top module: `ser_frame_tx`

## Requirements
- R1: After reset and between frames `txd_o` is 1. A word moves into the shifter in the first cycle in which the shifter is idle and the holding register is full. The start bit (0) begins on the next cycle and lasts 16 ticks.
- R2: `wlen_i` sets the data bit count (0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8). The data bits follow the start bit least significant first, and each lasts 16 ticks.
- R3: With `par_en_i`=1 and `par_fix_i`=0, one parity bit of 16 ticks follows the data bits. With `par_odd_i`=0 it makes the count of ones across data and parity even, and with `par_odd_i`=1 it makes that count odd. With `par_en_i`=0 no parity bit is sent.
- R4: With `par_en_i`=1 and `par_fix_i`=1, the parity bit is a fixed level equal to `par_odd_i`, whatever the data.
- R5: With `stop_long_i`=0, the stop period is one bit (16 ticks) at every word length.
- R6: With `stop_long_i`=1, the stop period is 24 ticks for 5-bit words and 32 ticks for 6, 7 or 8-bit words.
- R7: While `brk_i`=1, `txd_o` is 0 in the same cycle. The frame timing goes on underneath, and clearing `brk_i` gives the line back to the frame in that cycle.
- R8: `hold_empty_o` falls on the cycle after a load and rises on the cycle after the word moves into the shifter. A load while the holding register is full replaces the waiting word.
- R9: `tx_empty_o` is 1 only when the holding register is empty and no frame is in progress.
- R10: A word waiting when a stop period ends moves into the shifter on the tick that ends the stop period. Its start bit begins on the next cycle, with no idle bit in between.
- R11: The format inputs and the word are captured when the word moves into the shifter. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| data_i | input | 8 | Word to send |
| load_i | input | 1 | Writes data_i into the holding register |
| wlen_i | input | 2 | Word length code |
| stop_long_i | input | 1 | Long stop period select |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | Parity sense (1 = odd) or fixed level |
| par_fix_i | input | 1 | Fixed-level parity enable |
| brk_i | input | 1 | Forces the line low |
| txd_o | output | 1 | Serial output line |
| hold_empty_o | output | 1 | Holding register empty |
| tx_empty_o | output | 1 | Holding register and shifter both empty |

## Verification
The assertions assume only that `tick_i` is a single-cycle strobe. Any spacing is allowed, including a tick on every cycle, and loads and break may come at any time, even in the middle of a frame. The stimulus spaces ticks by 1, 2 and 3 cycles. It loads words during frames, loads twice in a row to overwrite a waiting word, and changes the format inputs and break mid-frame. A behavioural model built from queued per-tick line levels predicts the line and both flags on every cycle.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop_long;
    logic       par_en;
    logic       par_odd;
    logic       par_fix;
  } line_cfg_t;

  function automatic logic [3:0] wlen_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction
endpackage

// File: rtl/tx_holding.sv
module tx_holding #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);
  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (load_i) begin
        full_q <= 1'b1;
        data_q <= data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  p_load_fills_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> full_q);
  p_take_drains_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !load_i) |=> !full_q);
  p_take_needs_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q);
endmodule

// File: rtl/tx_parity.sv
module tx_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic [3:0]    nbits_i,
  input  logic          odd_i,
  input  logic          fix_i,
  output logic          par_o
);
  logic [DW-1:0] mask;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (4'(i) < nbits_i);
  end

  // even sense: bit equals XOR of data; odd sense inverts; fixed: level = sense
  assign par_o = fix_i ? odd_i : ((^(data_i & mask)) ^ odd_i);
endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer
  import ser_tx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          word_rdy_i,
  input  logic [DW-1:0] word_i,
  input  line_cfg_t     cfg_i,
  input  logic          par_i,
  output logic          take_o,
  output logic          line_o,
  output logic          idle_o
);
  localparam int TCW = $clog2(2 * OSR);
  localparam int BW  = $clog2(DW);
  localparam logic [TCW-1:0] BIT_END    = TCW'(OSR - 1);
  localparam logic [TCW-1:0] STOP1_END  = TCW'(OSR - 1);
  localparam logic [TCW-1:0] STOP15_END = TCW'(OSR + OSR / 2 - 1);
  localparam logic [TCW-1:0] STOP2_END  = TCW'(2 * OSR - 1);

  tx_state_e      state_q;
  logic [TCW-1:0] cnt_q;
  logic [BW-1:0]  bidx_q;
  logic [DW-1:0]  shreg_q;
  logic [3:0]     nbits_q;
  logic           par_en_q;
  logic           par_q;
  logic [TCW-1:0] stop_end_q;
  logic [TCW-1:0] stop_end_d;
  logic           stop_done;
  logic           bit_done;
  logic           last_data;

  assign bit_done  = tick_i && (cnt_q == BIT_END);
  assign stop_done = (state_q == ST_STOP) && tick_i && (cnt_q == stop_end_q);
  assign take_o    = word_rdy_i && ((state_q == ST_IDLE) || stop_done);
  assign last_data = ({1'b0, bidx_q} + 4'd1) == nbits_q;

  always_comb begin
    if (!cfg_i.stop_long)       stop_end_d = STOP1_END;
    else if (cfg_i.wlen == 2'd0) stop_end_d = STOP15_END;
    else                         stop_end_d = STOP2_END;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      bidx_q     <= '0;
      shreg_q    <= '0;
      nbits_q    <= 4'd5;
      par_en_q   <= 1'b0;
      par_q      <= 1'b0;
      stop_end_q <= STOP1_END;
    end else if (take_o) begin
      state_q    <= ST_START;
      cnt_q      <= '0;
      bidx_q     <= '0;
      shreg_q    <= word_i;
      nbits_q    <= wlen_bits(cfg_i.wlen);
      par_en_q   <= cfg_i.par_en;
      par_q      <= par_i;
      stop_end_q <= stop_end_d;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: ;
        ST_START: begin
          if (bit_done) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: begin
          if (bit_done) begin
            cnt_q   <= '0;
            shreg_q <= shreg_q >> 1;
            if (last_data) state_q <= par_en_q ? ST_PAR : ST_STOP;
            else bidx_q <= bidx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_PAR: begin
          if (bit_done) begin
            state_q <= ST_STOP;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_STOP: begin
          if (cnt_q == stop_end_q) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign idle_o = (state_q == ST_IDLE);

  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !take_o) |=> ($stable(cnt_q) && $stable(state_q)));
  p_bidx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> ({1'b0, bidx_q} < nbits_q));
  p_stop_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> (cnt_q <= stop_end_q));
  p_start_follows_take_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (state_q == ST_START && cnt_q == '0 && !line_o));
  p_par_only_enabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAR) |-> par_en_q);
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ser_tx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] data_i,
  input  logic       load_i,
  input  logic [1:0] wlen_i,
  input  logic       stop_long_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       par_fix_i,
  input  logic       brk_i,
  output logic       txd_o,
  output logic       hold_empty_o,
  output logic       tx_empty_o
);
  localparam int DW = 8;

  line_cfg_t     cfg;
  logic [DW-1:0] hold_data;
  logic          hold_full;
  logic          take;
  logic          par_bit;
  logic          line;
  logic          idle;

  assign cfg = '{wlen: wlen_i, stop_long: stop_long_i, par_en: par_en_i,
                 par_odd: par_odd_i, par_fix: par_fix_i};

  tx_holding #(.DW(DW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .data_i (data_i),
    .take_i (take),
    .data_o (hold_data),
    .full_o (hold_full)
  );

  tx_parity #(.DW(DW)) u_par (
    .data_i  (hold_data),
    .nbits_i (wlen_bits(wlen_i)),
    .odd_i   (par_odd_i),
    .fix_i   (par_fix_i),
    .par_o   (par_bit)
  );

  tx_sequencer #(.OSR(OSR), .DW(DW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .word_rdy_i (hold_full),
    .word_i     (hold_data),
    .cfg_i      (cfg),
    .par_i      (par_bit),
    .take_o     (take),
    .line_o     (line),
    .idle_o     (idle)
  );

  assign txd_o        = line & ~brk_i;
  assign hold_empty_o = ~hold_full;
  assign tx_empty_o   = ~hold_full & idle;

  p_brk_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_o);
  p_empty_needs_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> hold_empty_o);
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !brk_i) |-> txd_o);
endmodule

// File: tb/tb_ser_frame_tx.sv
module tb_ser_frame_tx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       load_i = 1'b0;
  logic [1:0] wlen_i = 2'd3;
  logic       stop_long_i = 1'b0;
  logic       par_en_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic       par_fix_i = 1'b0;
  logic       brk_i = 1'b0;
  logic       txd_o, hold_empty_o, tx_empty_o;

  int total = 0;
  int bad = 0;
  int tick_per = 2;
  int tcnt = 0;
  bit done = 0;
  string note = "";

  // reference model state
  bit    m_full = 0;
  bit    m_busy = 0;
  logic [7:0] m_data = '0;
  bit    q_lvl[$];
  string q_tag[$];

  always #5 clk = ~clk;

  ser_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .data_i(data_i),
    .load_i(load_i), .wlen_i(wlen_i), .stop_long_i(stop_long_i),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .par_fix_i(par_fix_i),
    .brk_i(brk_i), .txd_o(txd_o), .hold_empty_o(hold_empty_o),
    .tx_empty_o(tx_empty_o)
  );

  task automatic push_slots(input bit lvl, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      q_lvl.push_back(lvl);
      q_tag.push_back(tag);
    end
  endtask

  task automatic build_frame(input logic [7:0] d, input string start_tag);
    int nb;
    bit p;
    nb = 5 + int'(wlen_i);
    push_slots(1'b0, 16, start_tag);               // R1 start bit
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      push_slots(d[i], 16, "R2");                 // R2 lsb first
      p = p ^ d[i];
    end
    if (par_en_i) begin
      if (par_fix_i) push_slots(par_odd_i, 16, "R4");
      else push_slots(p ^ par_odd_i, 16, "R3");
    end
    if (!stop_long_i) push_slots(1'b1, 16, "R5");
    else push_slots(1'b1, (nb == 5) ? 24 : 32, "R6");
  endtask

  always @(posedge clk) begin
    bit take;
    bit ended;
    if (!rst_ni) begin
      m_full = 0; m_busy = 0; q_lvl.delete(); q_tag.delete();
    end else begin
      ended = 0;
      take = m_full && (!m_busy || (tick_i && q_lvl.size() == 1));
      if (m_busy && tick_i) begin
        void'(q_lvl.pop_front());
        void'(q_tag.pop_front());
        if (q_lvl.size() == 0) begin m_busy = 0; ended = 1; end
      end
      if (take) begin
        build_frame(m_data, ended ? "R10" : "R1");
        m_busy = 1;
      end
      if (load_i) begin m_full = 1; m_data = data_i; end
      else if (take) m_full = 0;
    end
  end

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s %s: act=%0b exp=%0b t=%0t", tag, note, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from both edges
  always @(negedge clk) begin
    bit    e_txd;
    string tg;
    #2;
    if (!rst_ni) begin
      check(txd_o, 1'b1, "R1", "reset txd");
      check(hold_empty_o, 1'b1, "R8", "reset hold_empty");
      check(tx_empty_o, 1'b1, "R9", "reset tx_empty");
    end else if (!done) begin
      if (brk_i) begin e_txd = 1'b0; tg = "R7"; end
      else if (m_busy) begin e_txd = q_lvl[0]; tg = q_tag[0]; end
      else begin e_txd = 1'b1; tg = "R1"; end
      check(txd_o, e_txd, tg, "txd");
      check(hold_empty_o, !m_full, "R8", "hold_empty");
      check(tx_empty_o, !m_full && !m_busy, "R9", "tx_empty");
    end
  end

  always @(negedge clk) begin
    if (tick_per <= 1) tick_i <= 1'b1;
    else begin
      tcnt = tcnt + 1;
      tick_i <= (tcnt % tick_per) == 0;
    end
  end

  task automatic cfg(input int w, input bit sl, input bit pe, input bit po, input bit pf);
    wlen_i = 2'(w); stop_long_i = sl; par_en_i = pe; par_odd_i = po; par_fix_i = pf;
  endtask

  task automatic load_word(input logic [7:0] d);
    @(negedge clk);
    while (!hold_empty_o) @(negedge clk);
    data_i = d; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_empty_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int k;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    k = 0;
    // R2 R3 R4 R5 R6 sweep of every format
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 2; s++)
        for (int pm = 0; pm < 5; pm++) begin
          cfg(w, s[0], pm != 0, pm == 2 || pm == 4, pm >= 3);
          load_word(8'(8'h3c + k * 37));
          k++;
          wait_idle();
        end
    // R1 fast and slow tick spacing
    tick_per = 1;
    cfg(3, 0, 1, 1, 0); load_word(8'h81); wait_idle();
    cfg(0, 1, 0, 0, 0); load_word(8'h1f); wait_idle();
    tick_per = 3;
    cfg(2, 1, 1, 0, 0); load_word(8'h6d); wait_idle();
    tick_per = 2;
    // R10 back-to-back words
    cfg(3, 0, 0, 0, 0);
    load_word(8'h55); load_word(8'haa); load_word(8'h0f); wait_idle();
    cfg(0, 1, 1, 1, 1);
    load_word(8'h13); load_word(8'h0c); wait_idle();
    // R8 overwrite of a waiting word
    cfg(1, 0, 1, 0, 0);
    load_word(8'hf0);
    @(negedge clk);
    data_i = 8'h21; load_i = 1'b1; @(negedge clk);
    data_i = 8'h5e; load_i = 1'b1; @(negedge clk);
    load_i = 1'b0;
    wait_idle();
    // R7 break mid-frame and idle
    cfg(3, 1, 1, 0, 0);
    load_word(8'hc3);
    repeat (60) @(negedge clk);
    brk_i = 1'b1; repeat (90) @(negedge clk); brk_i = 1'b0;
    wait_idle();
    brk_i = 1'b1; repeat (20) @(negedge clk); brk_i = 1'b0;
    repeat (5) @(negedge clk);
    // R11 format change during a frame
    note = "R11";
    cfg(0, 0, 0, 0, 0);
    load_word(8'h9a);
    repeat (10) @(negedge clk);
    cfg(3, 1, 1, 1, 1); data_i = 8'h77;
    wait_idle();
    note = "";
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule